// File: doc/BRIEF.md
# Memory-Mapped ATA Register Window

This block sits between an 8-bit host memory bus and the register file of an ATA/IDE device. It claims a fixed 1 KiB window of host memory space, placed at a parameterised base just above the option-ROM area. The ATA registers are reached with ordinary memory reads and writes, never through I/O cycles. The lower half of the window is the data page. Every one of its 512 byte addresses selects the one 16-bit device data register (CS0, register 0). An incrementing block-move string instruction can therefore stream a whole sector of 256 words without a software loop. The address advance comes from the host, the word advance comes from the device, and the block keeps no counter.

The upper half of the window is the register page. It carries 8-bit command, status and control accesses to either chip-select bank. The block steers the byte lanes between the 8-bit host and the 16-bit data register. An even-offset data read fetches a whole word, returns its low byte and holds its high byte for the following odd-offset read. An even-offset data write holds its byte until the odd-offset write, which then issues one 16-bit device write. Each device strobe stays low for a parameterised number of clocks, and the host acknowledge waits until that time has passed.

Top module: `ata_win_bridge`

## Requirements
- R1: A request whose address bits [19:10] differ from the window base produces no device strobe, no acknowledge and no host data drive.
- R2: In the data page (address bit 9 = 0), every offset from 0 to 511 reaches device register 0 under CS0. Address bits [8:1] have no effect on the access.
- R3: A data read at an even offset (bit 0 = 0) issues exactly one device read strobe and returns bits [7:0] of the word the device presents.
- R4: A data read at an odd offset returns bits [15:8] of the word captured by the most recent even-offset data read. It issues no device strobe.
- R5: A data write at an even offset is acknowledged without any device strobe. Its byte is held as the low byte of the next word.
- R6: A data write at an odd offset issues exactly one device write. The word driven is {odd byte, held even byte}, with the odd byte in bits [15:8].
- R7: In the register page (bit 9 = 1), bit 3 selects CS0 (0) or CS1 (1), and bits [2:0] pass straight through as the device register address. A read returns device bits [7:0]. A write drives {8'h00, byte}. Each access uses one strobe.
- R8: Every device read or write strobe stays low for at least STROBE_CYC consecutive clocks. The acknowledge comes only after the strobe ends.
- R9: The acknowledge lasts exactly one clock. Host read data is driven only in that clock, and only for reads.
- R10: After reset, both chip-selects and both strobes are high, and the acknowledge and host data enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | One-clock access request, sampled when idle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 20 | Host byte address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, valid during acknowledge |
| host_rdata_oe_o | output | 1 | Host data bus drive enable |
| host_ack_o | output | 1 | One-clock completion (ready) pulse |
| dev_cs0_n_o | output | 1 | Device chip-select bank 0, active low |
| dev_cs1_n_o | output | 1 | Device chip-select bank 1, active low |
| dev_addr_o | output | 3 | Device register address |
| dev_rd_n_o | output | 1 | Device read strobe, active low |
| dev_wr_n_o | output | 1 | Device write strobe, active low |
| dev_data_i | input | 16 | Device read data |
| dev_data_o | output | 16 | Device write data |
| dev_data_oe_o | output | 1 | Device data bus drive enable |

## Verification
Two functions can fall on the same clock edge. At the edge where a device read strobe ends, the word is captured for the host byte and the high byte is stored for the next odd access. The bench provokes this with a device model that moves to the next sector word when the read strobe rises. A wrong capture edge would return a byte from the following word. Each even/odd pair is judged against the computed word sequence, and the pairs use scattered aliased offsets. Strobe widths and the gap between acknowledge and data enable are also measured at the pins on every access.

// File: rtl/ata_win_pkg.sv
package ata_win_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DRD_LO,
    ACC_DRD_HI,
    ACC_DWR_LO,
    ACC_DWR_HI,
    ACC_REG_RD,
    ACC_REG_WR
  } acc_e;

  typedef struct packed {
    acc_e       kind;
    logic       cs1;
    logic [2:0] reg_a;
  } dec_t;

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_ACK} st_e;

  function automatic logic acc_is_read(acc_e k);
    return (k == ACC_DRD_LO) || (k == ACC_DRD_HI) || (k == ACC_REG_RD);
  endfunction

  function automatic logic acc_needs_dev(acc_e k);
    return (k == ACC_DRD_LO) || (k == ACC_DWR_HI) || (k == ACC_REG_RD) || (k == ACC_REG_WR);
  endfunction
endpackage

// File: rtl/ata_win_decode.sv
module ata_win_decode
  import ata_win_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 20,
  parameter int unsigned          WIN_W     = 10,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 20'hCC000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output dec_t              dec_o
);
  localparam int unsigned PAGE_BIT = WIN_W - 1;

  logic hit;
  assign hit = (addr_i[ADDR_W-1:WIN_W] == BASE_ADDR[ADDR_W-1:WIN_W]);

  always_comb begin
    dec_o = '{kind: ACC_NONE, cs1: 1'b0, reg_a: 3'd0};
    if (hit) begin
      if (!addr_i[PAGE_BIT]) begin
        // data page: low address bits ignored, always CS0 reg 0
        if (we_i) dec_o.kind = addr_i[0] ? ACC_DWR_HI : ACC_DWR_LO;
        else      dec_o.kind = addr_i[0] ? ACC_DRD_HI : ACC_DRD_LO;
      end else begin
        dec_o.kind  = we_i ? ACC_REG_WR : ACC_REG_RD;
        dec_o.cs1   = addr_i[3];
        dec_o.reg_a = addr_i[2:0];
      end
    end
  end
endmodule

// File: rtl/ata_win_timer.sv
module ata_win_timer #(
  parameter int unsigned STROBE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);
  localparam int unsigned CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign active_o = act_q;
  assign last_o   = act_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == LAST) act_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ata_win_lanes.sv
module ata_win_lanes (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_cap_i,
  input  logic [15:0] dev_word_i,
  input  logic        wr_hold_i,
  input  logic [7:0]  wr_byte_i,
  output logic [7:0]  rd_hi_o,
  output logic [7:0]  wr_lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hi_o <= '0;
      wr_lo_o <= '0;
    end else begin
      if (rd_cap_i)  rd_hi_o <= dev_word_i[15:8];
      if (wr_hold_i) wr_lo_o <= wr_byte_i;
    end
  end
endmodule

// File: rtl/ata_win_bridge.sv
module ata_win_bridge
  import ata_win_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 20,
  parameter int unsigned       WIN_W      = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 20'hCC000,
  parameter int unsigned       STROBE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              host_rdata_oe_o,
  output logic              host_ack_o,
  output logic              dev_cs0_n_o,
  output logic              dev_cs1_n_o,
  output logic [2:0]        dev_addr_o,
  output logic              dev_rd_n_o,
  output logic              dev_wr_n_o,
  input  logic [15:0]       dev_data_i,
  output logic [15:0]       dev_data_o,
  output logic              dev_data_oe_o
);
  dec_t dec, op_q;
  st_e  st_q;
  logic [7:0] wdata_q, rdata_q, rd_hi, wr_lo;
  logic strb, strb_last, accept, start;

  ata_win_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(host_addr_i), .we_i(host_we_i), .dec_o(dec)
  );

  assign accept = (st_q == S_IDLE) && host_req_i && (dec.kind != ACC_NONE);
  assign start  = accept && acc_needs_dev(dec.kind);

  ata_win_timer #(.STROBE_CYC(STROBE_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .active_o(strb), .last_o(strb_last)
  );

  ata_win_lanes u_lanes (
    .clk_i, .rst_ni,
    .rd_cap_i  (strb_last && (op_q.kind == ACC_DRD_LO)),
    .dev_word_i(dev_data_i),
    .wr_hold_i (accept && (dec.kind == ACC_DWR_LO)),
    .wr_byte_i (host_wdata_i),
    .rd_hi_o   (rd_hi),
    .wr_lo_o   (wr_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= '{kind: ACC_NONE, cs1: 1'b0, reg_a: 3'd0};
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          op_q    <= dec;
          wdata_q <= host_wdata_i;
          if (dec.kind == ACC_DRD_HI) rdata_q <= rd_hi;
          st_q <= acc_needs_dev(dec.kind) ? S_STRB : S_ACK;
        end
        S_STRB: if (strb_last) begin
          if (acc_is_read(op_q.kind)) rdata_q <= dev_data_i[7:0];
          st_q <= S_ACK;
        end
        S_ACK:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic op_rd;
  assign op_rd = acc_is_read(op_q.kind);

  assign dev_cs0_n_o   = !(strb && !op_q.cs1);
  assign dev_cs1_n_o   = !(strb && op_q.cs1);
  assign dev_addr_o    = strb ? op_q.reg_a : 3'd0;
  assign dev_rd_n_o    = !(strb && op_rd);
  assign dev_wr_n_o    = !(strb && !op_rd);
  assign dev_data_oe_o = strb && !op_rd;
  assign dev_data_o    = (op_q.kind == ACC_DWR_HI) ? {wdata_q, wr_lo} : {8'h00, wdata_q};

  assign host_ack_o      = (st_q == S_ACK);
  assign host_rdata_oe_o = host_ack_o && op_rd;
  assign host_rdata_o    = host_rdata_oe_o ? rdata_q : 8'h00;

  // strobe width monitor for assertions
  localparam int unsigned LW = $clog2(STROBE_CYC + 2);
  logic [LW-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               low_cnt_q <= '0;
    else if (!(dev_rd_n_o && dev_wr_n_o)) begin
      if (low_cnt_q < LW'(STROBE_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
    end else                                   low_cnt_q <= '0;
  end

  a_r1_miss_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_IDLE) && host_req_i && (dec.kind == ACC_NONE)) |=>
      (dev_rd_n_o && dev_wr_n_o && !host_ack_o && !host_rdata_oe_o));
  a_r4_odd_rd_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_IDLE) && host_req_i && (dec.kind == ACC_DRD_HI)) |=>
      (dev_rd_n_o && host_ack_o));
  a_r5_even_wr_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_IDLE) && host_req_i && (dec.kind == ACC_DWR_LO)) |=>
      (dev_wr_n_o && host_ack_o));
  a_r7_cs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!dev_cs0_n_o, !dev_cs1_n_o}) && (!(dev_rd_n_o && dev_wr_n_o) -> !(dev_cs0_n_o && dev_cs1_n_o)));
  a_r8_strobe_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dev_rd_n_o) || $rose(dev_wr_n_o)) |-> (low_cnt_q >= LW'(STROBE_CYC)));
  a_r8_no_ack_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> (dev_rd_n_o && dev_wr_n_o));
  a_r9_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);
  a_r9_oe_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_oe_o |-> host_ack_o);
endmodule

// File: tb/ata_win_bridge_tb.sv
module ata_win_bridge_tb_top;
  localparam logic [19:0] BASE = 20'hCC000;
  localparam int STROBE_CYC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, ack, cs0_n, cs1_n, rd_n, wr_n, ddata_oe;
  logic [2:0] daddr;
  logic [15:0] ddata_i, ddata_o;

  always #10 clk = ~clk;

  ata_win_bridge #(.BASE_ADDR(BASE), .STROBE_CYC(STROBE_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_rdata_oe_o(rdata_oe), .host_ack_o(ack),
    .dev_cs0_n_o(cs0_n), .dev_cs1_n_o(cs1_n), .dev_addr_o(daddr), .dev_rd_n_o(rd_n),
    .dev_wr_n_o(wr_n), .dev_data_i(ddata_i), .dev_data_o(ddata_o), .dev_data_oe_o(ddata_oe)
  );

  // device model: data register yields next sector word after each read strobe
  int wi = 0;
  function automatic logic [15:0] word_of(int i);
    return {8'(i) ^ 8'h5A, 8'(i)};
  endfunction
  assign ddata_i = (!cs0_n && daddr == 3'd0) ? word_of(wi)
                                              : {8'hFF, 8'h40 | {4'h0, !cs1_n, daddr}};

  int n_chk = 0, n_bad = 0;
  int rd_falls = 0, wr_falls = 0, rd_len = 0, last_rd_len = 0, wr_len = 0, last_wr_len = 0;
  int bad_oe = 0, bad_ack = 0;
  logic [15:0] wr_cap = '0;
  logic [3:0]  wr_sel = '0;
  bit prev_rd = 1, prev_wr = 1, prev_ack = 0, rd_data_flag = 0;

  always @(negedge clk) begin
    if (!rd_n) begin
      rd_len++;
      if (prev_rd) rd_falls++;
      if (!cs0_n && daddr == 3'd0) rd_data_flag = 1;
    end else if (!prev_rd) begin
      last_rd_len = rd_len; rd_len = 0;
      if (rd_data_flag) wi++;
      rd_data_flag = 0;
    end
    if (!wr_n) begin
      wr_len++;
      if (prev_wr) wr_falls++;
      wr_cap = ddata_o;
      wr_sel = {!cs1_n, daddr};
    end else if (!prev_wr) begin
      last_wr_len = wr_len; wr_len = 0;
    end
    if (rdata_oe && !ack) bad_oe++;
    if (ack && prev_ack) bad_ack++;
    prev_rd = rd_n; prev_wr = wr_n; prev_ack = ack;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [19:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output bit acked);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    acked = 0; rd = 8'h00;
    for (int i = 0; i < 40 && !acked; i++) begin
      if (ack) begin acked = 1; rd = rdata; end
      else @(negedge clk);
    end
  endtask

  // {we, off[9:0], wdata, exp_rdata, n_rd[1:0], n_wr[1:0], exp_wword[15:0], exp_sel[3:0]}
  localparam int NV = 13;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 10'h000, 8'h00, 8'h00, 2'd1, 2'd0, 16'h0000, 4'h0},  // R3
    {1'b0, 10'h001, 8'h00, 8'h5A, 2'd0, 2'd0, 16'h0000, 4'h0},  // R4
    {1'b0, 10'h1FE, 8'h00, 8'h01, 2'd1, 2'd0, 16'h0000, 4'h0},  // R2
    {1'b0, 10'h123, 8'h00, 8'h5B, 2'd0, 2'd0, 16'h0000, 4'h0},  // R2 R4
    {1'b0, 10'h0A4, 8'h00, 8'h02, 2'd1, 2'd0, 16'h0000, 4'h0},
    {1'b0, 10'h0A5, 8'h00, 8'h58, 2'd0, 2'd0, 16'h0000, 4'h0},
    {1'b1, 10'h010, 8'h34, 8'h00, 2'd0, 2'd0, 16'h0000, 4'h0},  // R5
    {1'b1, 10'h1F1, 8'h12, 8'h00, 2'd0, 2'd1, 16'h1234, 4'h0},  // R6
    {1'b0, 10'h207, 8'h00, 8'h47, 2'd1, 2'd0, 16'h0000, 4'h0},  // R7
    {1'b0, 10'h20E, 8'h00, 8'h4E, 2'd1, 2'd0, 16'h0000, 4'h0},
    {1'b1, 10'h202, 8'h99, 8'h00, 2'd0, 2'd1, 16'h0099, 4'h2},
    {1'b1, 10'h20F, 8'h0C, 8'h00, 2'd0, 2'd1, 16'h000C, 4'hF},
    {1'b0, 10'h3FF, 8'h00, 8'h4F, 2'd1, 2'd0, 16'h0000, 4'h0}
  };

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    bit acked;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs0_n && cs1_n && rd_n && wr_n && !ack && !rdata_oe, "R10 reset outputs",
        {cs0_n, cs1_n, rd_n, wr_n, ack, rdata_oe}, 6'b111100);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [50:0] e;
      e = VEC[v];
      rd_falls = 0; wr_falls = 0;
      access(e[50], BASE | 20'(e[49:40]), e[39:32], rd, acked);
      repeat (2) @(negedge clk);
      chk(acked, $sformatf("R9 ack vec%0d", v), acked, 1);
      if (!e[50]) chk(rd == e[31:24], $sformatf("R3/R4/R7 rdata vec%0d", v), rd, e[31:24]);
      chk(rd_falls == int'(e[23:22]), $sformatf("R3 R4 read strobes vec%0d", v), rd_falls, e[23:22]);
      chk(wr_falls == int'(e[21:20]), $sformatf("R5 R6 write strobes vec%0d", v), wr_falls, e[21:20]);
      if (e[21:20] != 2'd0) begin
        chk(wr_cap == e[19:4], $sformatf("R6 R7 write word vec%0d", v), wr_cap, e[19:4]);
        chk(wr_sel == e[3:0], $sformatf("R7 write select vec%0d", v), wr_sel, e[3:0]);
      end
    end

    // R8 strobe width
    access(1'b0, BASE | 20'h0066, 8'h00, rd, acked);
    repeat (2) @(negedge clk);
    chk(last_rd_len >= STROBE_CYC, "R8 read strobe width", last_rd_len, STROBE_CYC);
    chk(rd == 8'h03, "R2 R3 word 3 low", rd, 8'h03);
    chk(last_wr_len >= STROBE_CYC, "R8 write strobe width", last_wr_len, STROBE_CYC);

    // R1 out of window: no strobe, no ack, no data drive
    rd_falls = 0; wr_falls = 0;
    access(1'b0, BASE ^ 20'h00400, 8'h00, rd, acked);
    chk(!acked && rd_falls == 0, "R1 miss read", {acked, 8'(rd_falls)}, 0);
    access(1'b1, BASE ^ 20'h80000, 8'hAA, rd, acked);
    chk(!acked && wr_falls == 0, "R1 miss write", {acked, 8'(wr_falls)}, 0);
    chk(wi == 4, "R1 R2 device word index", wi, 4);

    // R9 whole-run pulse and data-enable discipline
    chk(bad_oe == 0, "R9 data enable outside ack", bad_oe, 0);
    chk(bad_ack == 0, "R9 ack longer than one clock", bad_ack, 0);
    finish_run();
  end
endmodule